// File: doc/BRIEF.md
# Fractional PLL Output Rate Calculator

This block works out the output frequency that a fractional-N synthesiser produces for a given reference frequency and divider setting. A request carries a 64-bit reference frequency, two 32-bit control words that hold the divider fields, and a mode bit that selects integer or fractional operation. A one-cycle start pulse latches all of these. The block then decodes the fields and forms the scaled numerator with a bit-serial shift-add multiplier. A bit-serial restoring divider divides it by the pre/post divider product. The result is a 64-bit frequency, returned with a one-cycle done pulse.

In fractional mode a signed 16-bit fraction is added to the main divider, which is scaled by 65536. The post divider acts as a left shift of the denominator by 0 to 7 places. In integer mode the second control word plays no part. A zero pre divider is reported as an error instead of being divided.

Top module: `fracpll_rate_calc`

## Requirements
- R1: Control word 0 is decoded by position: main divider m = bits 21:12, pre divider p = bits 9:4, post divider s = bits 2:0. Bits 31:22, 11:10 and 3 have no effect on the result.
- R2: When mode_int_i = 0, the result is Fin × (m × 65536 + k) / ((p × 65536) << s). Here k is bits 15:0 of control word 1, read as a two's-complement signed value.
- R3: When mode_int_i = 1, the result is Fin × m / (p << s). Control word 1 has no effect on the result.
- R4: The quotient truncates toward zero. freq_o carries the low 64 bits of that quotient in two's complement, so a negative quotient appears as its 64-bit two's-complement pattern.
- R5: If p = 0, the request completes with freq_o = 0 and err_o = 1 in the same cycle as done_o.
- R6: done_o is high for exactly one cycle per accepted request. err_o is never high without done_o.
- R7: busy_o goes high in the cycle after start_i is accepted and stays high until the done cycle. A start_i pulse while busy_o is high is ignored, and the inputs then present do not affect the running request.
- R8: With the default sizes, done_o is asserted no more than 121 clock edges after the accepting edge (FACT_W + PROD_W + 3). For p = 0 it is asserted at the first edge after acceptance.
- R9: While rst is high, busy_o, done_o and err_o are low and freq_o is 0 after the next edge.
- R10: freq_o changes only in a done cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse; accepted only when busy_o is low |
| mode_int_i | input | 1 | 1 = integer mode, 0 = fractional mode |
| fref_i | input | 64 | Reference frequency |
| ctrl0_i | input | 32 | Divider word holding m, p and s |
| ctrl1_i | input | 32 | Fraction word holding signed k in bits 15:0 |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero pre divider, valid with done_o |
| freq_o | output | 64 | Computed output frequency, held between completions |

## Verification
The bound checker watches the handshake on every cycle: done is a single-cycle pulse, an error never appears without done and always carries a zero result, busy rises only after a start, busy is low in the done cycle, the result holds between completions, a busy window never exceeds the latency bound, and reset clears the outputs. The arithmetic cannot be seen by a property. Field decoding, the signed fraction, truncation of negative quotients toward zero, wrap-around to the low 64 bits, integer mode ignoring the fraction word, and a start that is rejected while busy are all shown only by the bench. The bench compares its scenarios against values it computes from the formulas.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    // Sizes of the request and the divider fields
    localparam int REF_W     = 64;
    localparam int CW_W      = 32;
    localparam int MDIV_W    = 10;
    localparam int MDIV_LSB  = 12;
    localparam int PDIV_W    = 6;
    localparam int PDIV_LSB  = 4;
    localparam int SDIV_W    = 3;
    localparam int SDIV_LSB  = 0;
    localparam int KFRAC_W   = 16;
    localparam int KFRAC_LSB = 0;
    localparam int FRAC_BITS = 16;

    // Derived datapath widths
    localparam int FACT_W   = MDIV_W + FRAC_BITS + 1;              // |m*2^16 + k|
    localparam int PROD_W   = REF_W + FACT_W;                      // Fin * factor
    localparam int DEN_W    = PDIV_W + FRAC_BITS + (1 << SDIV_W) - 1;
    localparam int CALC_LAT = FACT_W + PROD_W + 3;                 // edges accept->done

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_MUL,
        ST_DIV
    } calc_state_e;

    typedef struct packed {
        logic [MDIV_W-1:0]         mdiv;
        logic [PDIV_W-1:0]         pdiv;
        logic [SDIV_W-1:0]         sdiv;
        logic signed [KFRAC_W-1:0] kfrac;
    } div_fields_t;

    typedef struct packed {
        logic              neg;
        logic [FACT_W-1:0] fact_mag;
        logic [DEN_W-1:0]  den;
        logic              den_zero;
    } rate_job_t;

    function automatic div_fields_t unpack_fields(input logic [CW_W-1:0] w0,
                                                  input logic [CW_W-1:0] w1);
        div_fields_t f;
        f.mdiv  = w0[MDIV_LSB +: MDIV_W];
        f.pdiv  = w0[PDIV_LSB +: PDIV_W];
        f.sdiv  = w0[SDIV_LSB +: SDIV_W];
        f.kfrac = w1[KFRAC_LSB +: KFRAC_W];
        return f;
    endfunction

endpackage

// File: rtl/fpc_field_decode.sv
module fpc_field_decode
    import fpc_pkg::*;
(
    input  logic            mode_int,
    input  logic [CW_W-1:0] word0,
    input  logic [CW_W-1:0] word1,
    output rate_job_t       job
);

    div_fields_t             fld;
    logic signed [FACT_W:0]  m_term;
    logic signed [FACT_W:0]  k_term;
    logic signed [FACT_W:0]  fact_s;
    logic [FACT_W:0]         fact_abs;
    logic [DEN_W-1:0]        p_ext;

    always_comb begin
        fld = unpack_fields(word0, word1);

        if (mode_int) begin
            m_term = {{(FACT_W + 1 - MDIV_W){1'b0}}, fld.mdiv};
            k_term = '0;
        end else begin
            m_term = {{(FACT_W + 1 - MDIV_W - FRAC_BITS){1'b0}}, fld.mdiv, {FRAC_BITS{1'b0}}};
            k_term = {{(FACT_W + 1 - KFRAC_W){fld.kfrac[KFRAC_W-1]}}, fld.kfrac};
        end
        fact_s   = m_term + k_term;
        fact_abs = fact_s[FACT_W] ? (-fact_s) : fact_s;

        if (mode_int)
            p_ext = DEN_W'(fld.pdiv);
        else
            p_ext = DEN_W'({fld.pdiv, {FRAC_BITS{1'b0}}});

        job.neg      = fact_s[FACT_W];
        job.fact_mag = fact_abs[FACT_W-1:0];
        job.den      = p_ext << fld.sdiv;
        job.den_zero = (fld.pdiv == '0);
    end

endmodule

// File: rtl/fpc_shift_mult.sv
module fpc_shift_mult #(
    parameter int A_W = 64,
    parameter int B_W = 27
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    output logic [A_W+B_W-1:0] prod,
    output logic               done
);

    localparam int P_W   = A_W + B_W;
    localparam int CNT_W = $clog2(B_W + 1);

    logic [P_W-1:0]   acc;
    logic [P_W-1:0]   mcand;
    logic [B_W-1:0]   mplier;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            mcand  <= '0;
            mplier <= '0;
            cnt    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                acc    <= '0;
                mcand  <= {{B_W{1'b0}}, a};
                mplier <= b;
                cnt    <= CNT_W'(B_W);
            end else if (cnt != '0) begin
                if (mplier[0])
                    acc <= acc + mcand;
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                cnt    <= cnt - 1'b1;
                if (cnt == CNT_W'(1))
                    done <= 1'b1;
            end
        end
    end

    assign prod = acc;

endmodule

// File: rtl/fpc_restoring_div.sv
module fpc_restoring_div #(
    parameter int N_W = 91,
    parameter int D_W = 29,
    parameter int Q_W = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [N_W-1:0] num,
    input  logic [D_W-1:0] den,
    output logic [Q_W-1:0] quo,
    output logic           done
);

    localparam int CNT_W = $clog2(N_W + 1);

    logic [N_W-1:0]   num_sh;
    logic [D_W-1:0]   den_q;
    logic [D_W-1:0]   rem;
    logic [CNT_W-1:0] cnt;
    logic [D_W:0]     trial;
    logic [D_W:0]     diff;
    logic             fits;

    always_comb begin
        trial = {rem, num_sh[N_W-1]};
        diff  = trial - {1'b0, den_q};
        fits  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            num_sh <= '0;
            den_q  <= '0;
            rem    <= '0;
            quo    <= '0;
            cnt    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                num_sh <= num;
                den_q  <= den;
                rem    <= '0;
                quo    <= '0;
                cnt    <= CNT_W'(N_W);
            end else if (cnt != '0) begin
                num_sh <= num_sh << 1;
                if (fits) begin
                    rem <= diff[D_W-1:0];
                    quo <= {quo[Q_W-2:0], 1'b1};
                end else begin
                    rem <= trial[D_W-1:0];
                    quo <= {quo[Q_W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1))
                    done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fracpll_rate_calc.sv
module fracpll_rate_calc
    import fpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             mode_int_i,
    input  logic [REF_W-1:0] fref_i,
    input  logic [CW_W-1:0]  ctrl0_i,
    input  logic [CW_W-1:0]  ctrl1_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [REF_W-1:0] freq_o
);

    calc_state_e      state;
    logic             mode_q;
    logic [REF_W-1:0] fref_q;
    logic [CW_W-1:0]  w0_q;
    logic [CW_W-1:0]  w1_q;
    rate_job_t        job;

    logic              mul_go;
    logic              mul_done;
    logic [PROD_W-1:0] mul_prod;
    logic              div_go;
    logic              div_done;
    logic [REF_W-1:0]  div_quo;

    fpc_field_decode u_decode (
        .mode_int (mode_q),
        .word0    (w0_q),
        .word1    (w1_q),
        .job      (job)
    );

    assign mul_go = (state == ST_PREP) && !job.den_zero;
    assign div_go = (state == ST_MUL) && mul_done;

    fpc_shift_mult #(
        .A_W (REF_W),
        .B_W (FACT_W)
    ) u_mult (
        .clk  (clk),
        .rst  (rst),
        .go   (mul_go),
        .a    (fref_q),
        .b    (job.fact_mag),
        .prod (mul_prod),
        .done (mul_done)
    );

    fpc_restoring_div #(
        .N_W (PROD_W),
        .D_W (DEN_W),
        .Q_W (REF_W)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (mul_prod),
        .den  (job.den),
        .quo  (div_quo),
        .done (div_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_q <= 1'b0;
            fref_q <= '0;
            w0_q   <= '0;
            w1_q   <= '0;
            freq_o <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q <= mode_int_i;
                        fref_q <= fref_i;
                        w0_q   <= ctrl0_i;
                        w1_q   <= ctrl1_i;
                        state  <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    if (job.den_zero) begin
                        freq_o <= '0;
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    if (mul_done)
                        state <= ST_DIV;
                end
                ST_DIV: begin
                    if (div_done) begin
                        freq_o <= job.neg ? (-div_quo) : div_quo;
                        done_o <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker
    import fpc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic [REF_W-1:0] freq_o
);

    localparam int LC_W = $clog2(CALC_LAT + 1) + 1;

    logic [LC_W-1:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            lat_cnt <= '0;
        else if (busy_o) begin
            if (lat_cnt != {LC_W{1'b1}})
                lat_cnt <= lat_cnt + 1'b1;
        end else
            lat_cnt <= '0;
    end

    // R9
    assert_reset_clean_R9: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && !err_o && freq_o == '0));

    // R6
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_err_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    // R5
    assert_err_zero_R5: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (freq_o == '0));

    // R10
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(freq_o));

    // R7
    assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R8
    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (lat_cnt < LC_W'(CALC_LAT)));

endmodule

bind fracpll_rate_calc fpc_checker u_fpc_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .freq_o  (freq_o)
);

// File: tb/fracpll_rate_calc_bench.sv
`timescale 1ns/1ps
module fracpll_rate_calc_bench;
    import fpc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        mode_int_i = 1'b0;
    logic [63:0] fref_i = '0;
    logic [31:0] ctrl0_i = '0;
    logic [31:0] ctrl1_i = '0;
    logic        busy_o;
    logic        done_o;
    logic        err_o;
    logic [63:0] freq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    fracpll_rate_calc u_fracpll_rate_calc (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .mode_int_i (mode_int_i),
        .fref_i     (fref_i),
        .ctrl0_i    (ctrl0_i),
        .ctrl1_i    (ctrl1_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .freq_o     (freq_o)
    );

    typedef struct packed {
        logic        imode;
        logic [63:0] fref;
        logic [9:0]  m;
        logic [5:0]  p;
        logic [2:0]  s;
        logic [15:0] k;
        logic [63:0] expv;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 64'd24000000, 10'd173, 6'd2, 3'd1, 16'd16384, 64'd1039500000},
        '{1'b0, 64'd24000000, 10'd325, 6'd3, 3'd2, 16'd0,     64'd650000000},
        '{1'b0, 64'd24000000, 10'd198, 6'd2, 3'd2, 16'd0,     64'd594000000},
        '{1'b0, 64'd24000000, 10'd262, 6'd2, 3'd3, 16'd9437,  64'd393215995},
        '{1'b1, 64'd24000000, 10'd225, 6'd3, 3'd0, 16'd0,     64'd1800000000},
        '{1'b1, 64'd24000000, 10'd375, 6'd3, 3'd1, 16'd0,     64'd1500000000},
        '{1'b1, 64'd24000000, 10'd200, 6'd3, 3'd1, 16'd0,     64'd800000000}
    };

    function automatic logic [31:0] mk_w0(input logic [9:0] m, input logic [5:0] p,
                                          input logic [2:0] s);
        return {10'd0, m, 2'd0, p, 1'b0, s};
    endfunction

    // Reference model straight from the formulas (signed division truncates toward zero)
    function automatic logic [63:0] model(input logic im, input logic [63:0] fr,
                                          input logic [9:0] m, input logic [5:0] p,
                                          input logic [2:0] s, input logic [15:0] k);
        logic signed [127:0] num;
        logic signed [127:0] fac;
        logic signed [127:0] den;
        logic signed [127:0] q;
        if (p == 0) return 64'd0;
        if (im) begin
            fac = $signed({118'd0, m});
            den = $signed({122'd0, p}) <<< s;
        end else begin
            fac = $signed({118'd0, m}) * 128'sd65536 + $signed({{112{k[15]}}, k});
            den = ($signed({122'd0, p}) * 128'sd65536) <<< s;
        end
        num = $signed({64'd0, fr}) * fac;
        q   = num / den;
        return q[63:0];
    endfunction

    task automatic check64(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_job(input logic im, input logic [63:0] fr,
                           input logic [31:0] w0, input logic [31:0] w1,
                           output logic [63:0] res, output logic er, output int cyc);
        @(negedge clk);
        mode_int_i = im; fref_i = fr; ctrl0_i = w0; ctrl1_i = w1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        res = freq_o;
        er  = err_o;
        @(negedge clk);
        check64("R6", "done width", {63'd0, done_o}, 64'd0);
        check64("R10", "hold after done", freq_o, res);
    endtask

    initial begin
        logic [63:0] res;
        logic [63:0] res2;
        logic        er;
        int          cyc;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check64("R9", "busy", {63'd0, busy_o}, 64'd0);
        check64("R9", "done", {63'd0, done_o}, 64'd0);
        check64("R9", "err",  {63'd0, err_o},  64'd0);
        check64("R9", "freq", freq_o, 64'd0);
        rst = 1'b0;

        // Table walk: R2 fractional, R3 integer, R4 truncation, R8 latency
        for (int i = 0; i < NVEC; i++) begin
            run_job(VECS[i].imode, VECS[i].fref, mk_w0(VECS[i].m, VECS[i].p, VECS[i].s),
                    {16'd0, VECS[i].k}, res, er, cyc);
            check64(VECS[i].imode ? "R3" : "R2", "table result", res, VECS[i].expv);
            check64("R2", "model agrees", VECS[i].expv,
                    model(VECS[i].imode, VECS[i].fref, VECS[i].m, VECS[i].p, VECS[i].s, VECS[i].k));
            check64("R6", "no err", {63'd0, er}, 64'd0);
            check64("R8", "latency bound", {63'd0, (cyc <= CALC_LAT)}, 64'd1);
        end

        // R1: stray bits in control word 0 must not matter
        run_job(1'b0, 64'd24000000, mk_w0(10'd173, 6'd2, 3'd1) | 32'hFFC0_0C08,
                32'h0000_4000, res, er, cyc);
        check64("R1", "stray bits", res, 64'd1039500000);

        // R3: integer mode ignores control word 1
        run_job(1'b1, 64'd19200000, mk_w0(10'd77, 6'd5, 3'd2), 32'h0000_0000, res, er, cyc);
        run_job(1'b1, 64'd19200000, mk_w0(10'd77, 6'd5, 3'd2), 32'hFFFF_FFFF, res2, er, cyc);
        check64("R3", "fraction word ignored", res2, res);
        check64("R3", "integer value", res, model(1'b1, 64'd19200000, 10'd77, 6'd5, 3'd2, 16'd0));

        // R2: negative fraction with a nonzero main divider
        run_job(1'b0, 64'd27000000, mk_w0(10'd361, 6'd3, 3'd3), 32'h0000_8001, res, er, cyc);
        check64("R2", "negative k", res, model(1'b0, 64'd27000000, 10'd361, 6'd3, 3'd3, 16'h8001));

        // R4: negative quotient truncates toward zero
        run_job(1'b0, 64'd100000, mk_w0(10'd0, 6'd1, 3'd0), 32'h0000_FFFF, res, er, cyc);
        check64("R4", "toward zero", res, 64'hFFFF_FFFF_FFFF_FFFF);
        run_job(1'b0, 64'd1000000, mk_w0(10'd0, 6'd1, 3'd0), 32'h0000_8000, res, er, cyc);
        check64("R4", "exact negative", res, 64'hFFFF_FFFF_FFF8_5EE0);

        // R4: only the low 64 bits of a large quotient are kept
        run_job(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, mk_w0(10'd2, 6'd1, 3'd0), 32'd0, res, er, cyc);
        check64("R4", "wrap low bits", res, 64'hFFFF_FFFF_FFFF_FFFE);
        run_job(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, mk_w0(10'd1023, 6'd63, 3'd7), 32'd0, res, er, cyc);
        check64("R4", "max divisors", res,
                model(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 10'd1023, 6'd63, 3'd7, 16'd0));

        // R5: zero pre divider
        run_job(1'b0, 64'd24000000, mk_w0(10'd100, 6'd0, 3'd1), 32'd0, res, er, cyc);
        check64("R5", "zero result", res, 64'd0);
        check64("R5", "err flag", {63'd0, er}, 64'd1);
        check64("R8", "err latency", cyc, 64'd1);

        // R7: start while busy is ignored
        @(negedge clk);
        mode_int_i = 1'b1; fref_i = 64'd24000000; ctrl0_i = mk_w0(10'd200, 6'd3, 3'd1);
        ctrl1_i = 32'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        fref_i = 64'd1000; ctrl0_i = mk_w0(10'd1, 6'd1, 3'd0); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check64("R7", "still busy", {63'd0, busy_o}, 64'd1);
        cyc = 0;
        while (!done_o && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        check64("R7", "first job result", freq_o, 64'd800000000);
        cyc = 0;
        for (int j = 0; j < CALC_LAT + 10; j++) begin
            @(negedge clk);
            if (done_o || busy_o) cyc++;
        end
        check64("R7", "no second job", cyc, 64'd0);
        check64("R10", "result held", freq_o, 64'd800000000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule